// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block holds the number of bytes still to move in a DMA transfer on a SCSI-style protocol controller. Software writes the start value one byte at a time into a staging area. The value moves into the live counter only when a command carrying the DMA qualifier is issued. From then on, each byte-transfer strobe takes one off the count. When the count reaches zero the block raises a sticky zero flag and gives a single-cycle done pulse.

A mode input picks the counter width. With the mode input low, the counter is 16 bits wide and only the low and middle bytes are used. With the mode input high, it is 24 bits wide and the high byte takes part as well. A start value of zero means the largest transfer the current width allows, not an empty one. While the mode input is low, the high-byte read location returns a fixed identification code instead of count bits.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset the count is 0, the zero flag and the done pulse are low, and all staged bytes are 0.
- R2: A byte write (wr_sel 0 = low, 1 = middle, 2 = high, 3 = discarded) changes only the staged value and leaves the count unchanged. A command with cmd_dma low also leaves the count unchanged.
- R3: A command with cmd_dma high loads the count on the next clock edge. With wide_mode low the value is middle*256 + low, and the high byte is ignored. With wide_mode high the value is high*65536 + middle*256 + low.
- R4: A staged value of zero loads 65536 when wide_mode is low and 16777216 when wide_mode is high.
- R5: Each byte_strobe lowers a nonzero count by exactly one. At zero the count stays at zero.
- R6: The zero flag rises at the edge where the count steps from 1 to 0. It stays high until the next DMA load, and that load clears it.
- R7: done_pulse is high for exactly the one cycle after the edge where the count steps from 1 to 0. It does not rise on strobes that arrive while the count is already zero.
- R8: rd_data returns count bits 7:0 for rd_sel 0 and bits 15:8 for rd_sel 1. For rd_sel 2 with wide_mode high it returns bits 23:16. For rd_sel 3 it returns 0.
- R9: For rd_sel 2 with wide_mode low, rd_data returns the identification code: family code in bits 7:3 and revision in bits 2:0. The default is family 2, revision 1, which reads as 0x11.
- R10: When a DMA load and a byte_strobe arrive in the same cycle, the load wins and the strobe has no effect.
- R11: When a byte write and a DMA load arrive in the same cycle, the load uses the staged bytes as they were before that write. The new byte is kept for a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe for the staging area |
| wr_sel | input | 2 | Staged byte to write: 0 low, 1 middle, 2 high |
| wr_data | input | 8 | Byte to write |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_dma | input | 1 | DMA qualifier bit of the command (bit 7 of its code) |
| wide_mode | input | 1 | 1 selects the 24-bit counter, 0 the 16-bit counter |
| byte_strobe | input | 1 | One byte was transferred |
| rd_sel | input | 2 | Readback location: 0 low, 1 middle, 2 high or ID, 3 none |
| rd_data | output | 8 | Readback byte, combinational |
| count | output | 25 | Live count; bit 24 set only for a full 24-bit transfer |
| zero_flag | output | 1 | Sticky terminal-count flag |
| done_pulse | output | 1 | One-cycle pulse on reaching zero |

## Verification
Two pairs of events can land in the same cycle. A DMA load can coincide with a byte strobe, and a byte write can coincide with the load that reads the staged bytes. The bench provokes both with directed cycles, including a strobe on the very cycle that would otherwise bring the count to zero. It also mixes all of these inputs at random. Each case is judged against a bench model that applies the load first, discards the strobe and commits the write only after the load has taken the old bytes.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    LOC_LOW  = 2'd0,
    LOC_MID  = 2'd1,
    LOC_HIGH = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;

  // Number of staged bytes a given width uses.
  function automatic int bytes_for(input logic wide, input int narrow_n, input int wide_n);
    return wide ? wide_n : narrow_n;
  endfunction
endpackage

// File: rtl/xbc_stage.sv
module xbc_stage
  import xbc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  localparam int FLAT_W = BYTE_W * N_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FLAT_W-1:0] staged
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (int'(wr_sel) == g);
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign staged[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/xbc_core.sv
module xbc_core #(
  parameter int BYTE_W   = 8,
  parameter int NARROW_N = 2,
  parameter int WIDE_N   = 3,
  localparam int CNT_W    = BYTE_W * WIDE_N,
  localparam int NARROW_W = BYTE_W * NARROW_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             wide_mode,
  input  logic             byte_strobe,
  input  logic [CNT_W-1:0] staged,
  output logic [CNT_W:0]   count,
  output logic             zero_flag,
  output logic             done_pulse,
  output logic             dec_evt,
  output logic             hit_zero
);
  // Start value: zero stands for the full range of the chosen width.
  function automatic logic [CNT_W:0] start_value(input logic [CNT_W-1:0] s, input logic wide);
    logic [CNT_W:0] v;
    v = '0;
    if (wide) v[CNT_W-1:0]    = s;
    else      v[NARROW_W-1:0] = s[NARROW_W-1:0];
    if (v == '0) begin
      if (wide) v[CNT_W]    = 1'b1;
      else      v[NARROW_W] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [CNT_W:0] step_down(input logic [CNT_W:0] c);
    return c - (CNT_W+1)'(1);
  endfunction

  logic cnt_nonzero;
  logic cnt_is_one;
  assign cnt_nonzero = (count != '0);
  assign cnt_is_one  = (count == (CNT_W+1)'(1));
  assign dec_evt     = byte_strobe && !load_evt && cnt_nonzero;
  assign hit_zero    = dec_evt && cnt_is_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      zero_flag  <= 1'b0;
      done_pulse <= 1'b0;
    end else if (load_evt) begin
      count      <= start_value(staged, wide_mode);
      zero_flag  <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      if (dec_evt) count <= step_down(count);
      if (hit_zero) zero_flag <= 1'b1;
      done_pulse <= hit_zero;
    end
  end
endmodule

// File: rtl/xbc_readmux.sv
module xbc_readmux
  import xbc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  parameter logic [BYTE_W-1:0] ID_CODE = '0,
  localparam int CNT_W = BYTE_W * N_BYTES
) (
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              wide_mode,
  input  logic [CNT_W-1:0]  cnt_bits,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] lane [N_BYTES];
  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    assign lane[g] = cnt_bits[g*BYTE_W +: BYTE_W];
  end

  loc_e loc;
  assign loc = loc_e'(rd_sel);

  always_comb begin
    unique case (loc)
      LOC_LOW:  rd_data = lane[0];
      LOC_MID:  rd_data = lane[1];
      LOC_HIGH: rd_data = wide_mode ? lane[2] : ID_CODE;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xbc_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NARROW_N = 2,
  parameter int WIDE_N   = 3,
  parameter logic [4:0] FAMILY_CODE = 5'd2,
  parameter logic [2:0] REVISION    = 3'd1,
  localparam int CNT_W = BYTE_W * WIDE_N,
  localparam logic [BYTE_W-1:0] ID_CODE = BYTE_W'({FAMILY_CODE, REVISION})
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic              cmd_dma,
  input  logic              wide_mode,
  input  logic              byte_strobe,
  input  logic [1:0]        rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W:0]    count,
  output logic              zero_flag,
  output logic              done_pulse
);
  logic [CNT_W-1:0] staged;
  logic             load_evt;
  logic             dec_evt;
  logic             hit_zero;

  assign load_evt = cmd_valid && cmd_dma;

  xbc_stage #(.BYTE_W(BYTE_W), .N_BYTES(WIDE_N)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .staged(staged)
  );

  xbc_core #(.BYTE_W(BYTE_W), .NARROW_N(NARROW_N), .WIDE_N(WIDE_N)) u_core (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .wide_mode(wide_mode),
    .byte_strobe(byte_strobe), .staged(staged), .count(count),
    .zero_flag(zero_flag), .done_pulse(done_pulse),
    .dec_evt(dec_evt), .hit_zero(hit_zero)
  );

  xbc_readmux #(.BYTE_W(BYTE_W), .N_BYTES(WIDE_N), .ID_CODE(ID_CODE)) u_rd (
    .rd_sel(rd_sel), .wide_mode(wide_mode), .cnt_bits(count[CNT_W-1:0]),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int BYTE_W   = 8,
  parameter int NARROW_N = 2,
  parameter int WIDE_N   = 3,
  parameter logic [BYTE_W-1:0] ID_CODE = '0,
  localparam int CNT_W    = BYTE_W * WIDE_N,
  localparam int NARROW_W = BYTE_W * NARROW_N
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_evt,
  input logic              wide_mode,
  input logic              byte_strobe,
  input logic [1:0]        rd_sel,
  input logic [BYTE_W-1:0] rd_data,
  input logic [CNT_W:0]    count,
  input logic              zero_flag,
  input logic              done_pulse
);
  localparam logic [CNT_W:0] NARROW_MAX = (CNT_W+1)'(1) << NARROW_W;

  a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> count != '0);

  a_r4_narrow_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wide_mode) |=> count <= NARROW_MAX);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_strobe && !load_evt && count != '0) |=> count == $past(count) - (CNT_W+1)'(1));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_evt) |=> count == '0);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !byte_strobe) |=> $stable(count));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag && !load_evt) |=> zero_flag);

  a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (count == '0 && zero_flag));

  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r9_id: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd2 && !wide_mode) |-> rd_data == ID_CODE);
endmodule

bind xfer_byte_counter xbc_checker #(
  .BYTE_W(BYTE_W), .NARROW_N(NARROW_N), .WIDE_N(WIDE_N), .ID_CODE(ID_CODE)
) u_xbc_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .wide_mode(wide_mode),
  .byte_strobe(byte_strobe), .rd_sel(rd_sel), .rd_data(rd_data),
  .count(count), .zero_flag(zero_flag), .done_pulse(done_pulse)
);

// File: tb/test_xfer_byte_counter.sv
module test_xfer_byte_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_dma = 1'b0;
  logic        wide_mode = 1'b0;
  logic        byte_strobe = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [24:0] count;
  logic        zero_flag;
  logic        done_pulse;

  always #10 clk = ~clk;

  xfer_byte_counter i_xfer_byte_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .wide_mode(wide_mode),
    .byte_strobe(byte_strobe), .rd_sel(rd_sel), .rd_data(rd_data),
    .count(count), .zero_flag(zero_flag), .done_pulse(done_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_cnt = 0;
  bit exp_zero = 0;
  bit exp_done = 0;
  int stg [3] = '{0, 0, 0};

  function automatic int load_of(int lo, int mid, int hi, bit wide);
    int n;
    n = lo + mid * 256;
    if (wide) n = n + hi * 65536;
    if (n == 0) n = wide ? 16777216 : 65536;
    return n;
  endfunction

  function automatic int read_of(int c, int sel, bit wide);
    case (sel)
      0: return c % 256;
      1: return (c / 256) % 256;
      2: return wide ? (c / 65536) % 256 : 8'h11;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One clock: inputs already driven; update model at the edge, check at negedge.
  task automatic cyc(string tag);
    @(posedge clk);
    if (cmd_valid && cmd_dma) begin
      exp_cnt = load_of(stg[0], stg[1], stg[2], wide_mode);
      exp_zero = 0; exp_done = 0;
    end else if (byte_strobe && exp_cnt != 0) begin
      exp_cnt--;
      exp_done = (exp_cnt == 0);
      if (exp_cnt == 0) exp_zero = 1;
    end else exp_done = 0;
    if (wr_en && wr_sel != 2'd3) stg[wr_sel] = int'(wr_data);
    @(negedge clk);
    chk(int'(count) == exp_cnt, tag, int'(count), exp_cnt);
    chk(zero_flag == exp_zero, "R6 zero_flag", int'(zero_flag), int'(exp_zero));
    chk(done_pulse == exp_done, "R7 done_pulse", int'(done_pulse), int'(exp_done));
    wr_en = 0; cmd_valid = 0; cmd_dma = 0; byte_strobe = 0;
  endtask

  task automatic wr(int sel, int d, string tag);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(d); cyc(tag);
  endtask

  task automatic load(bit wide, string tag);
    wide_mode = wide; cmd_valid = 1; cmd_dma = 1; cyc(tag);
  endtask

  task automatic strobe(string tag);
    byte_strobe = 1; cyc(tag);
  endtask

  task automatic rd_check(int sel, string tag);
    rd_sel = 2'(sel);
    #1;
    chk(int'(rd_data) == read_of(exp_cnt, sel, wide_mode), tag,
        int'(rd_data), read_of(exp_cnt, sel, wide_mode));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(count == '0, "R1 count", int'(count), 0);
    chk(!zero_flag && !done_pulse, "R1 flags", int'({zero_flag, done_pulse}), 0);
    rd_check(0, "R1 low readback");
    // R2: writes and a plain command leave the count alone
    wr(0, 8'h05, "R2 write low");
    wr(1, 8'h01, "R2 write mid");
    wr(2, 8'h03, "R2 write high");
    cmd_valid = 1; cmd_dma = 0; cyc("R2 non-DMA command");
    // R3: narrow load ignores high byte -> 261
    load(0, "R3 narrow load");
    rd_check(0, "R8 low byte");
    rd_check(1, "R8 mid byte");
    rd_check(2, "R9 id code");
    rd_check(3, "R8 empty location");
    // R3: wide load uses high byte -> 3*65536+261
    load(1, "R3 wide load");
    rd_check(2, "R8 high byte wide");
    strobe("R5 decrement wide");
    // R11: write and load in one cycle use the old staged bytes
    wr_en = 1; wr_sel = 2'd2; wr_data = 8'h00; wide_mode = 1;
    cmd_valid = 1; cmd_dma = 1; cyc("R11 load with same-cycle write");
    load(1, "R11 later load sees new byte");
    // drain small value: low=2, mid=0
    wr(1, 0, "R2 write mid");
    wr(0, 2, "R2 write low");
    load(0, "R3 load 2");
    // R10: strobe with load is ignored
    byte_strobe = 1; cmd_valid = 1; cmd_dma = 1; cyc("R10 load beats strobe");
    strobe("R5 step to 1");
    // R10 at the edge that would reach zero
    byte_strobe = 1; cmd_valid = 1; cmd_dma = 1; cyc("R10 load beats final strobe");
    strobe("R5 step to 1");
    strobe("R6 reach zero");
    strobe("R5 saturate at zero");
    strobe("R7 no second pulse");
    // R4: zero loads
    wr(0, 0, "R2 write low");
    wr(2, 0, "R2 write high");
    load(1, "R4 wide zero load");
    rd_check(0, "R8 low of full wide");
    load(0, "R4 narrow zero load");
    rd_check(1, "R8 mid of full narrow");
    for (int i = 0; i < 65536; i++) strobe("R4 full narrow drain");
    strobe("R5 saturate after full drain");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 10);
      wide_mode = 1'($urandom % 2);
      if (op < 3) begin
        int s;
        s = int'($urandom % 4);
        wr(s, (s == 0) ? int'($urandom % 256) : int'($urandom % 2), "R2 random write");
      end else if (op == 3) begin
        load(wide_mode, "R3 random load");
      end else if (op == 4) begin
        cmd_valid = 1; cmd_dma = 0; cyc("R2 random plain command");
      end else if (op == 5) begin
        byte_strobe = 1; cmd_valid = 1; cmd_dma = 1; cyc("R10 random load and strobe");
      end else begin
        strobe("R5 random strobe");
      end
      if (i % 16 == 0) rd_check(int'($urandom % 4), "R8 random readback");
    end
    summary();
  end
endmodule